// File: doc/BRIEF.md
# Dual Backup Cell Selection Controller

This block is the digital core of a battery-backed memory supply. It does not sense analog levels itself. Comparators elsewhere report whether the main supply is below the power-fail threshold, whether it is below the switchover level, and whether either backup cell is higher than the other by the switch margin. The block decides which of the two cells may drive the memory supply rail during backup. It also decides whether the main supply drives that rail.

The block also keeps a battery-isolation latch. This latch disconnects both cells when no data needs to be kept. Two events set it. One is a pulse reporting that a cell was just attached. The other is an isolation command, given by holding the chip-enable at a mid level during power-down. Both chip-enable level flags come from comparators. A clock-enable tick sets the minimum hold time of the command. The latch clears when main power next returns above the power-fail threshold, so the chosen cell connects again on the following power loss.

Top module: `cell_backup_sel`

## Requirements
- R1: `main_en` is high exactly while `below_so` is low. While `below_so` is low, `cell1_on` and `cell2_on` are both low.
- R2: At most one of `cell1_on` and `cell2_on` is high at any time. A cell output is high only while `below_so` is high, `bat_link` is high and no isolation command occurs in that cycle. `cell1_on` is high when `sel_c2`=0 and `cell2_on` when `sel_c2`=1.
- R3: The selection `sel_c2` returns to 0 (cell 1) one cycle after any cycle in which `below_pfd` or `below_so` is low. Every backup period therefore starts on cell 1.
- R4: While `below_pfd` and `below_so` are both high, the selection moves one cycle later:
  - from cell 1 to cell 2 if `c2_gt_c1` is high;
  - from cell 2 to cell 1 if `c1_gt_c2` is high.

  Otherwise the selection holds.
- R5: A `cell_attach` pulse in a cycle with `below_pfd` high drives `bat_link` low from the next cycle. A pulse while `below_pfd` is low has no effect.
- R6: The power-down window is the time when `below_pfd` is high and `below_so` is low. A valid isolation command needs `ce_mid` high for QUAL_TICKS consecutive `tick` cycles inside that window, and `ce_high` low throughout the window. In the first cycle `below_so` is high after such a command, both cell outputs are low, and from the next cycle `bat_link` is low.
- R7: If `ce_high` is high in any cycle of the power-down window, no isolation command results on that power-down.
- R8: A cycle in the window with `ce_mid` low restarts the tick count. Runs of `ce_mid` shorter than QUAL_TICKS ticks never form a command.
- R9: `bat_link` returns high one cycle after any cycle with `below_pfd` low. The window record is cleared at the same point.
- R10: After reset, `bat_link` is high and `sel_c2` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock-enable tick used to time the isolation command |
| below_pfd | input | 1 | Main supply below the power-fail threshold |
| below_so | input | 1 | Main supply below the switchover level |
| c2_gt_c1 | input | 1 | Cell 2 exceeds cell 1 by more than the switch margin |
| c1_gt_c2 | input | 1 | Cell 1 exceeds cell 2 by more than the switch margin |
| cell_attach | input | 1 | Pulse: a cell has just been connected |
| ce_mid | input | 1 | Chip-enable inside the mid-level window |
| ce_high | input | 1 | Chip-enable above the invalid level |
| main_en | output | 1 | Main supply drives the memory rail |
| cell1_on | output | 1 | Cell 1 drives the memory rail |
| cell2_on | output | 1 | Cell 2 drives the memory rail |
| sel_c2 | output | 1 | Registered cell choice, 1 = cell 2 |
| bat_link | output | 1 | High when the cells are not isolated |

## Verification
The assertions rely on coherent comparator flags:
- `below_so` is never high unless `below_pfd` is high.
- `c2_gt_c1` and `c1_gt_c2` are never high together.

The stimulus respects both rules. The supply always moves through the power-down window, both going down and coming back up. The margin flags are driven as single directional pulses, never as an overlapping pair. The chip-enable flags vary only within these supply sequences. This lets valid, cancelled and interrupted isolation commands be compared on otherwise identical power-downs.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  // Width of a counter that must hold values 0..limit.
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // Next cell choice while alternation is enabled: 0 = cell 1, 1 = cell 2.
  function automatic logic alt_next(input logic cur, input logic up, input logic down);
    return cur ? ~down : up;
  endfunction
endpackage

// File: rtl/bsel_alternator.sv
module bsel_alternator
  import bsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic below_pfd,
  input  logic below_so,
  input  logic c2_gt_c1,
  input  logic c1_gt_c2,
  output logic sel
);
  logic alt_en;
  assign alt_en = below_pfd & below_so;

  always_ff @(posedge clk) begin
    if (!rst_n)       sel <= 1'b0;
    else if (!alt_en) sel <= 1'b0;
    else              sel <= alt_next(sel, c2_gt_c1, c1_gt_c2);
  end
endmodule

// File: rtl/bsel_iso_detect.sv
module bsel_iso_detect
  import bsel_pkg::*;
#(
  parameter int QUAL_TICKS = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic below_pfd,
  input  logic below_so,
  input  logic ce_mid,
  input  logic ce_high,
  output logic in_win,
  output logic iso_cmd
);
  localparam int CW = cnt_width(QUAL_TICKS);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_TICKS);

  logic [CW-1:0] cnt;
  logic          qual_q;
  logic          bad_q;
  logic          so_d;
  logic          so_rise;
  logic          cnt_full;

  assign in_win   = below_pfd & ~below_so;
  assign so_rise  = below_so & ~so_d;
  assign cnt_full = (cnt == LIMIT);
  assign iso_cmd  = so_rise & below_pfd & qual_q & ~bad_q;

  always_ff @(posedge clk) begin
    if (!rst_n) so_d <= 1'b0;
    else        so_d <= below_so;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !below_pfd) begin
      cnt    <= '0;
      qual_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (in_win) begin
      if (ce_high) bad_q <= 1'b1;
      if (!ce_mid) begin
        cnt <= '0;
      end else if (tick && !cnt_full) begin
        cnt <= cnt + 1'b1;
        if (cnt + 1'b1 == LIMIT) qual_q <= 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/cell_backup_sel.sv
module cell_backup_sel #(
  parameter int QUAL_TICKS = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic below_pfd,
  input  logic below_so,
  input  logic c2_gt_c1,
  input  logic c1_gt_c2,
  input  logic cell_attach,
  input  logic ce_mid,
  input  logic ce_high,
  output logic main_en,
  output logic cell1_on,
  output logic cell2_on,
  output logic sel_c2,
  output logic bat_link
);
  logic sel;
  logic in_win;
  logic iso_cmd;
  logic iso_q;
  logic feed_ok;

  bsel_alternator u_alt (
    .clk       (clk),
    .rst_n     (rst_n),
    .below_pfd (below_pfd),
    .below_so  (below_so),
    .c2_gt_c1  (c2_gt_c1),
    .c1_gt_c2  (c1_gt_c2),
    .sel       (sel)
  );

  bsel_iso_detect #(.QUAL_TICKS(QUAL_TICKS)) u_iso (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .below_pfd (below_pfd),
    .below_so  (below_so),
    .ce_mid    (ce_mid),
    .ce_high   (ce_high),
    .in_win    (in_win),
    .iso_cmd   (iso_cmd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                        iso_q <= 1'b0;
    else if (cell_attach && below_pfd) iso_q <= 1'b1;
    else if (!below_pfd)               iso_q <= 1'b0;
    else if (iso_cmd)                  iso_q <= 1'b1;
  end

  assign feed_ok  = below_so & ~iso_q & ~iso_cmd;
  assign main_en  = ~below_so;
  assign cell1_on = feed_ok & ~sel;
  assign cell2_on = feed_ok & sel;
  assign sel_c2   = sel;
  assign bat_link = ~iso_q;
endmodule

// File: rtl/bsel_checker.sv
module bsel_checker (
  input logic clk,
  input logic rst_n,
  input logic below_pfd,
  input logic below_so,
  input logic c2_gt_c1,
  input logic c1_gt_c2,
  input logic cell_attach,
  input logic iso_cmd,
  input logic cell1_on,
  input logic cell2_on,
  input logic sel_c2,
  input logic bat_link
);
  a_r3_start_c1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(below_so) |-> !sel_c2);

  a_r4_to_c2: assert property (@(posedge clk) disable iff (!rst_n)
    (below_pfd && below_so && !sel_c2 && c2_gt_c1) |=> sel_c2);

  a_r4_hold_c1: assert property (@(posedge clk) disable iff (!rst_n)
    (below_pfd && below_so && !sel_c2 && !c2_gt_c1) |=> !sel_c2);

  a_r4_to_c1: assert property (@(posedge clk) disable iff (!rst_n)
    (below_pfd && below_so && sel_c2 && c1_gt_c2) |=> !sel_c2);

  a_r5_attach_isolates: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_attach && below_pfd) |=> !bat_link);

  a_r6_cmd_isolates: assert property (@(posedge clk) disable iff (!rst_n)
    iso_cmd |=> (!bat_link && !cell1_on && !cell2_on));

  a_r9_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (!below_pfd && !cell_attach) |=> bat_link);
endmodule

bind cell_backup_sel bsel_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .below_pfd   (below_pfd),
  .below_so    (below_so),
  .c2_gt_c1    (c2_gt_c1),
  .c1_gt_c2    (c1_gt_c2),
  .cell_attach (cell_attach),
  .iso_cmd     (iso_cmd),
  .cell1_on    (cell1_on),
  .cell2_on    (cell2_on),
  .sel_c2      (sel_c2),
  .bat_link    (bat_link)
);

// File: tb/sim_cell_backup_sel.sv
module sim_cell_backup_sel;
  localparam int QT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, below_pfd = 1'b0, below_so = 1'b0;
  logic c2_gt_c1 = 1'b0, c1_gt_c2 = 1'b0, cell_attach = 1'b0;
  logic ce_mid = 1'b0, ce_high = 1'b0;
  logic main_en, cell1_on, cell2_on, sel_c2, bat_link;

  int vectors = 0;
  int errors = 0;
  string tag = "R10";

  // behavioural reference state
  bit m_sel = 0, m_iso = 0, m_qual = 0, m_bad = 0, m_prev_so = 0;
  int m_run = 0;

  always #5 clk = ~clk;

  cell_backup_sel #(.QUAL_TICKS(QT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .below_pfd(below_pfd), .below_so(below_so),
    .c2_gt_c1(c2_gt_c1), .c1_gt_c2(c1_gt_c2), .cell_attach(cell_attach),
    .ce_mid(ce_mid), .ce_high(ce_high), .main_en(main_en), .cell1_on(cell1_on),
    .cell2_on(cell2_on), .sel_c2(sel_c2), .bat_link(bat_link)
  );

  task automatic cmp(input string name, input logic act, input bit exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, name, act, exp, $time);
    end
  endtask

  // one clock: apply inputs, compare at mid-cycle, advance the model at the edge
  task automatic step(input bit pfd, input bit so, input bit up = 0, input bit dn = 0,
                      input bit att = 0, input bit mid = 0, input bit hi = 0, input bit tk = 1);
    bit cmd, feed;
    @(negedge clk);
    below_pfd = pfd; below_so = so; c2_gt_c1 = up; c1_gt_c2 = dn;
    cell_attach = att; ce_mid = mid; ce_high = hi; tick = tk;
    #1;
    cmd  = so && !m_prev_so && pfd && m_qual && !m_bad && rst_n;
    feed = so && !m_iso && !cmd;
    if (rst_n) begin
      cmp("main_en", main_en, !so);
      cmp("cell1_on", cell1_on, feed && !m_sel);
      cmp("cell2_on", cell2_on, feed && m_sel);
      cmp("sel_c2", sel_c2, m_sel);
      cmp("bat_link", bat_link, !m_iso);
    end
    @(posedge clk);
    if (!rst_n) begin
      m_sel = 0; m_iso = 0; m_qual = 0; m_bad = 0; m_prev_so = 0; m_run = 0;
    end else begin
      if (att && pfd) m_iso = 1;
      else if (!pfd) m_iso = 0;
      else if (cmd) m_iso = 1;
      if (!(pfd && so)) m_sel = 0;
      else if (!m_sel && up) m_sel = 1;
      else if (m_sel && dn) m_sel = 0;
      if (!pfd) begin m_run = 0; m_qual = 0; m_bad = 0; end
      else if (!so) begin
        if (hi) m_bad = 1;
        if (!mid) m_run = 0;
        else if (tk && m_run < QT) begin
          m_run++;
          if (m_run == QT) m_qual = 1;
        end
      end else m_run = 0;
      m_prev_so = so;
    end
  endtask

  task automatic power_up();
    step(1, 0); step(0, 0); step(0, 0);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: run did not end, got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    step(0, 0); step(0, 0);
    rst_n = 1'b1;
    tag = "R10"; step(0, 0); step(0, 0);

    tag = "R1"; step(0, 0, 1, 0); step(0, 0, 0, 1); step(0, 0, 1, 0, 1);
    tag = "R5"; step(0, 0); // attach above threshold had no effect

    tag = "R3"; step(1, 0, 1, 0); step(1, 0); step(1, 1); step(1, 1);
    tag = "R4"; step(1, 1, 1, 0); step(1, 1); step(1, 1, 1, 0); step(1, 1, 0, 1);
    step(1, 1); step(1, 1, 0, 1); step(1, 1, 1, 0); step(1, 1);
    tag = "R2"; step(1, 1); step(1, 1, 0, 1);
    tag = "R3"; step(1, 1, 1, 0); step(1, 0); step(1, 1); step(1, 1);
    tag = "R9"; power_up();

    // valid isolation command, ticks on alternate cycles
    tag = "R6";
    step(1, 0);
    for (int i = 0; i < 2 * QT + 2; i++) step(1, 0, 0, 0, 0, 1, 0, i[0]);
    step(1, 1); step(1, 1); step(1, 1, 1, 0); step(1, 1);
    tag = "R9"; power_up();
    step(1, 0); step(1, 1); step(1, 1);
    power_up();

    // cancelled by the invalid level
    tag = "R7";
    step(1, 0);
    for (int i = 0; i < QT + 2; i++) step(1, 0, 0, 0, 0, 1, (i == 3));
    step(1, 1); step(1, 1);
    power_up();

    // interrupted mid-level runs
    tag = "R8";
    step(1, 0);
    for (int i = 0; i < QT - 1; i++) step(1, 0, 0, 0, 0, 1);
    step(1, 0);
    for (int i = 0; i < QT - 1; i++) step(1, 0, 0, 0, 0, 1);
    step(1, 1); step(1, 1);
    power_up();

    // attach during backup
    tag = "R5";
    step(1, 0); step(1, 1); step(1, 1, 1, 0); step(1, 1, 0, 0, 1); step(1, 1); step(1, 1);
    tag = "R9"; power_up();
    tag = "R2"; step(1, 0); step(1, 1); step(1, 1);
    power_up();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule